// File: doc/BRIEF.md
# Signed-Step Successive Approximation Controller

This block is the digital half of a successive approximation converter. It keeps a signed fixed-point estimate of a normalized input in the range 0 to 1. A conversion begins with the estimate at zero. The block then runs a fixed number of refinement steps. In each step it moves the estimate down when an external comparator says the estimate is at or above the input, and up otherwise. The step size starts at one half and halves on every step, so after `WIDTH` steps the estimate lies within 2^-WIDTH of the input.

The estimate is driven out continuously so that an external DAC can turn it into the comparison voltage. Each step takes two clock cycles. In the first cycle the new estimate settles at the DAC and the comparator. In the second cycle the comparator bit is sampled and the accumulator is updated. When the last step is done, the final estimate is clamped into the unsigned range 0 to 1 − 2^-WIDTH and loaded onto the result bus, and a single-cycle completion flag is raised.

Top module: `sar_signed_step`

## Requirements
- R1: A synchronous active-high reset sets the estimate output to zero, the result bus to zero and the done flag low, and leaves the block idle.
- R2: The start input is sampled high at a rising edge while the block is idle. From that edge the estimate output reads zero for the next two cycles. The done flag is high in exactly the cycle after the 2·WIDTH-th rising edge that follows, and low during the conversion before then.
- R3: The estimate is two's complement, WIDTH+2 bits wide, with LSB weight 2^-(WIDTH+1). At the second rising edge of step i (i = 1..WIDTH) the estimate is lowered by 2^-i when the comparator bit is 1, and raised by 2^-i when it is 0. Its value always stays strictly above −1.
- R4: The comparator bit is used only at the second edge of each step. The estimate holds its value through both cycles of a step, so any comparator value during the settling cycle has no effect.
- R5: At completion the result bus takes the final estimate without its LSB (bits WIDTH..1) when the estimate is non-negative, and takes zero when it is negative.
- R6: A start pulse received while a conversion is running has no effect on the estimate sequence or on when the conversion completes.
- R7: The done flag is high for exactly one cycle per conversion. The result bus keeps its value at all other times, whatever the comparator does.
- R8: With an ideal comparator (1 when the estimate ≥ input, 0 otherwise), the final estimate is within 2^-WIDTH of the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a conversion when sampled high while idle |
| cmpGe | input | 1 | Comparator bit: 1 when the DAC voltage of the estimate is at or above the input |
| estOut | output | WIDTH+2 | Current signed estimate, driven to the external DAC |
| result | output | WIDTH | Clamped unsigned conversion result, LSB weight 2^-WIDTH |
| eoc | output | 1 | One-cycle end-of-conversion flag |

## Verification
Counting from the edge that samples start, the estimate for step i appears after edge 2i. The comparator that decides that step is read at edge 2i, and the done flag and result appear after edge 2·WIDTH. The bench drives every input at a falling edge. It reads each output at the falling edge that follows the edge where that output is due, and checks the estimate after every edge of every step against a model step taken in the bench. In the settling cycles the bench drives the comparator with the inverted value, and it pulses start in the middle of a conversion. Both should leave the sequence unchanged, and any stray sampling would show up as a wrong estimate at the next check.

// File: rtl/sar_step_pkg.sv
`timescale 1ns/1ps
package sar_step_pkg;

  // Strobes from the sequencer to the accumulator datapath.
  typedef struct packed {
    logic clear;   // zero the estimate at conversion start
    logic update;  // apply one signed step from the comparator bit
    logic finish;  // last step: load the clamped result, raise done
  } stepStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_SAMPLE = 2'd2
  } stepPhase_t;

endpackage

// File: rtl/sar_step_ctrl.sv
`timescale 1ns/1ps
module sar_step_ctrl
  import sar_step_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output stepStrobe_t      strb,
  output logic [IDX_W-1:0] stepIdx
);

  localparam logic [IDX_W-1:0] LAST_IDX  = IDX_W'(WIDTH);
  localparam logic [IDX_W-1:0] FIRST_IDX = IDX_W'(1);

  stepPhase_t phase;
  logic       lastStep;

  assign lastStep = (stepIdx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      stepIdx <= FIRST_IDX;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase   <= PH_SETTLE;
            stepIdx <= FIRST_IDX;
          end
        end
        PH_SETTLE: phase <= PH_SAMPLE;
        PH_SAMPLE: begin
          if (lastStep) begin
            phase <= PH_IDLE;
          end else begin
            phase   <= PH_SETTLE;
            stepIdx <= stepIdx + IDX_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strb        = '0;
    strb.clear  = (phase == PH_IDLE) && start;
    strb.update = (phase == PH_SAMPLE);
    strb.finish = (phase == PH_SAMPLE) && lastStep;
  end

  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (rst)
    (phase != PH_IDLE) |-> (stepIdx >= FIRST_IDX && stepIdx <= LAST_IDX)); // R2

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_SAMPLE && !lastStep && start) |=> (stepIdx == $past(stepIdx) + IDX_W'(1))); // R6

endmodule

// File: rtl/sar_step_dp.sv
`timescale 1ns/1ps
module sar_step_dp
  import sar_step_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int IDX_W = $clog2(WIDTH + 1),
  localparam int EST_W = WIDTH + 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  stepStrobe_t             strb,
  input  logic [IDX_W-1:0]        stepIdx,
  input  logic                    cmpGe,
  output logic signed [EST_W-1:0] est,
  output logic [WIDTH-1:0]        result,
  output logic                    eoc
);

  localparam logic signed [EST_W-1:0] EST_MOST_NEG = {1'b1, {(EST_W-1){1'b0}}};

  logic signed [EST_W-1:0] stepVal;
  logic signed [EST_W-1:0] nextEst;
  logic [WIDTH-1:0]        clampRes;

  // Step i has weight 2^-i; with LSB weight 2^-(WIDTH+1) that is 1 << (WIDTH+1-i).
  always_comb begin
    stepVal = EST_W'(1) << (WIDTH + 1 - int'(stepIdx));
    nextEst = cmpGe ? (est - stepVal) : (est + stepVal);
    clampRes = nextEst[EST_W-1] ? '0 : nextEst[WIDTH:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      est    <= '0;
      result <= '0;
      eoc    <= 1'b0;
    end else begin
      eoc <= strb.finish;
      if (strb.clear) begin
        est <= '0;
      end else if (strb.update) begin
        est <= nextEst;
      end
      if (strb.finish) begin
        result <= clampRes;
      end
    end
  end

  AST_EST_BOUND: assert property (@(posedge clk) disable iff (rst)
    est != EST_MOST_NEG); // R3

endmodule

// File: rtl/sar_signed_step.sv
`timescale 1ns/1ps
module sar_signed_step
  import sar_step_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               cmpGe,
  output logic [WIDTH+1:0]   estOut,
  output logic [WIDTH-1:0]   result,
  output logic               eoc
);

  localparam int IDX_W = $clog2(WIDTH + 1);
  localparam int EST_W = WIDTH + 2;

  stepStrobe_t             strb;
  logic [IDX_W-1:0]        stepIdx;
  logic signed [EST_W-1:0] est;

  sar_step_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .strb    (strb),
    .stepIdx (stepIdx)
  );

  sar_step_dp #(.WIDTH(WIDTH)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .stepIdx (stepIdx),
    .cmpGe   (cmpGe),
    .est     (est),
    .result  (result),
    .eoc     (eoc)
  );

  assign estOut = est;

  AST_EOC_PULSE: assert property (@(posedge clk) disable iff (rst)
    eoc |=> !eoc); // R7

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !eoc) |-> $stable(result)); // R7

  AST_SETTLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && strb.update) |-> $stable(estOut)); // R4

endmodule

// File: tb/sar_signed_step_tb.sv
`timescale 1ns/1ps
module sar_signed_step_tb;

  localparam int  WIDTH      = 8;
  localparam int  CLK_PERIOD = 10;
  localparam int  EXTRA      = 3;            // input resolution: 2^-(WIDTH+1+EXTRA)
  localparam int  X_FULL     = 1 << (WIDTH + 1 + EXTRA);
  localparam int  TOL        = 1 << (EXTRA + 1);  // 2^-WIDTH in input units
  localparam int  WATCHDOG   = 200000;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start = 1'b0;
  logic             cmpGe = 1'b0;
  logic [WIDTH+1:0] estOut;
  logic [WIDTH-1:0] result;
  logic             eoc;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sar_signed_step #(.WIDTH(WIDTH)) u_dut (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cmpGe  (cmpGe),
    .estOut (estOut),
    .result (result),
    .eoc    (eoc)
  );

  function automatic int estVal();
    return int'($signed(estOut));
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rst = 1'b1;
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(estVal() == 0, "R1 estimate after reset", estVal(), 0);
    check(result == '0, "R1 result after reset", int'(result), 0);
    check(eoc == 1'b0, "R1 done after reset", int'(eoc), 0);
  endtask

  // One full conversion against an ideal comparator for input xin.
  task automatic runConv(input int xin, input bit noisy, input bit pokeStart);
    int e = 0;
    int expRes;
    int diff;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);          // start sampled at edge E0
    start = 1'b0;
    for (int i = 1; i <= WIDTH; i++) begin
      // settling cycle of step i (after edge 2i-2)
      check(estVal() == e, "R2/R3 estimate at settle", estVal(), e);
      check(eoc == 1'b0, "R2 done low while busy", int'(eoc), 0);
      cmpGe = noisy ? !((e << EXTRA) >= xin) : ((e << EXTRA) >= xin);
      if (pokeStart && i == 2) start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // sampling cycle of step i (after edge 2i-1)
      check(estVal() == e, "R4 estimate held into sample cycle", estVal(), e);
      check(eoc == 1'b0, "R2 done low while busy", int'(eoc), 0);
      cmpGe = ((e << EXTRA) >= xin);
      if (cmpGe) e = e - (1 << (WIDTH + 1 - i));
      else       e = e + (1 << (WIDTH + 1 - i));
      @(negedge clk);
    end
    expRes = (e < 0) ? 0 : (e >> 1);
    check(estVal() == e, "R3 final estimate", estVal(), e);
    check(eoc == 1'b1, "R2 done after 2*WIDTH edges", int'(eoc), 1);
    check(int'(result) == expRes, "R5 clamped result", int'(result), expRes);
    diff = (e << EXTRA) - xin;
    if (diff < 0) diff = -diff;
    check(diff <= TOL, "R8 accuracy within 2^-WIDTH", diff, TOL);
    @(negedge clk);
    check(eoc == 1'b0, "R7 done lasts one cycle", int'(eoc), 0);
    check(int'(result) == expRes, "R7 result held after done", int'(result), expRes);
  endtask

  task automatic testHold();
    logic [WIDTH-1:0] held;
    held = result;
    for (int k = 0; k < 6; k++) begin
      cmpGe = k[0];
      @(negedge clk);
      check(result == held, "R7 result holds while idle", int'(result), int'(held));
      check(eoc == 1'b0, "R7 no done while idle", int'(eoc), 0);
    end
  endtask

  task automatic testResetMid();
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cmpGe = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(estVal() == 0, "R1 estimate after mid reset", estVal(), 0);
    check(result == '0, "R1 result after mid reset", int'(result), 0);
    check(eoc == 1'b0, "R1 done after mid reset", int'(eoc), 0);
    // idle after reset: no spontaneous progress
    cmpGe = 1'b0;
    repeat (3) @(negedge clk);
    check(estVal() == 0, "R1 idle estimate stays zero", estVal(), 0);
  endtask

  initial begin
    doReset();
    runConv(1000, 1'b0, 1'b0);                 // ordinary value
    runConv(X_FULL / 2, 1'b0, 1'b0);           // exact half: equality steps down
    runConv(0, 1'b0, 1'b0);                    // negative final estimate clamps to 0
    runConv(X_FULL - 1, 1'b0, 1'b0);           // top of range
    runConv(37, 1'b1, 1'b0);                   // R4: inverted comparator in settle cycles
    runConv(2900, 1'b1, 1'b1);                 // R6: start pulse mid conversion
    testHold();
    runConv(X_FULL / 3, 1'b0, 1'b1);           // R6 again, different pattern
    testResetMid();
    runConv(1234, 1'b0, 1'b0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule